// File: doc/BRIEF.md
# Multi-Width Lane Byte Shuffle Network

This block sits between a 512-byte cache line and a bank of 64 vector ALU lanes, each with a 64-bit input. Operands in a line may be doublewords, words, halfwords or bytes. The block reorders the line so that consecutive operands of the selected size reach consecutive lanes. It does not use a full crossbar. It builds every width from repeated passes of two fixed permutations:

- a global byte perfect-shuffle, which interleaves the two halves of the line;
- a local gather, which reorders the bytes inside each 8-byte lane.

A line holds more narrow operands than there are lanes. A group-select value therefore picks which slice of operands the lanes see on this pass: operands `g*64` to `g*64+63`. A per-lane mask then disables unused lanes. An inverse mode applies the inverse permutations in reverse order, which turns a lane-ordered line back into memory order for store-back.

Each pass takes one clock in a registered pipeline of four pass stages, followed by a lane-pick stage. A request made on one clock edge appears at the outputs five edges later, whatever its size or mode. The block accepts a new request every cycle.

Top module: `byte_lane_shuffle`

## Requirements
- R1: While `rst` is high, and after it, `out_valid`, `lane_valid` and `line_out` are all zero until an accepted request reaches the output. A request in flight when reset is asserted never appears at the output.
- R2: A request accepted with `in_valid` high on a clock edge produces `out_valid` high exactly five edges later, and `out_valid` is low on the edge before. This holds for every operand size and both modes. Requests may be issued on consecutive cycles, and their results come out in issue order, one per cycle.
- R3: `op_size` encoding 0 selects 64-bit operands. In forward mode, lane w receives bytes 8w to 8w+7 of the line unchanged.
- R4: Encoding 1 selects 32-bit operands. In forward mode, the low 32 bits of lane w hold operand number g*64+w. Operand n is bytes 4n to 4n+3, least significant byte first. The upper 32 bits of the lane are zero.
- R5: Encoding 2 selects 16-bit operands. In forward mode, the low 16 bits of lane w hold halfword number g*64+w, which is bytes 2n and 2n+1. All other bits of the lane are zero.
- R6: Encoding 3 selects 8-bit operands. In forward mode, the low byte of lane w holds line byte g*64+w. All other bits of the lane are zero.
- R7: The group g is `grp_sel` taken modulo the number of groups: 1, 2, 4 or 8 for sizes 64, 32, 16 and 8. Bits of `grp_sel` above that range have no effect.
- R8: In forward mode, a lane whose `lane_mask` bit is 0 has its `lane_valid` bit low and its 64-bit data zero. A lane whose mask bit is 1 has its `lane_valid` bit high.
- R9: In inverse mode, the output is the memory-order line whose forward permutation (R3 to R6, before lane picking) equals the input. All 64 `lane_valid` bits are high, and `lane_mask` and `grp_sel` have no effect.
- R10: On a cycle where no result is presented, `out_valid` is low and every `lane_valid` bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the other inputs are sampled on this edge |
| inverse | input | 1 | 0 = memory to lanes, 1 = lanes back to memory order |
| op_size | input | 2 | Operand size: 0 = 64, 1 = 32, 2 = 16, 3 = 8 bits |
| grp_sel | input | 3 | Operand group presented to the lanes (forward only) |
| lane_mask | input | 64 | Per-lane enable (forward only) |
| line_in | input | 4096 | Input line; byte i is bits 8i+7 to 8i |
| out_valid | output | 1 | Result strobe |
| lane_valid | output | 64 | Per-lane valid bits |
| line_out | output | 4096 | Lane words; lane w is bits 64w+63 to 64w |

## Verification
Suppose a pass stage applies the wrong permutation, or applies its steps in the wrong order. Every affected lane then shows bytes taken from the wrong operand group, or in the wrong order, exactly five cycles after issue. The round trip in inverse mode fails in the same cycle.

A wrong control value carried down the pipeline shows up in other ways:

- a wrong latency or a lost strobe shows as `out_valid` one edge early, one edge late, or missing;
- a wrong group value shows as a neighbouring operand slice;
- a lost mask shows as nonzero data or a high valid bit in a disabled lane.

Back-to-back issue of different sizes and modes exposes any stage that takes its control from the wrong request.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int LANE_BYTES  = 8;
    localparam int LANE_BITS   = LANE_BYTES * 8;
    localparam int PASS_STAGES = 4;

    typedef enum logic [1:0] {
        SZ_D64 = 2'd0,
        SZ_W32 = 2'd1,
        SZ_H16 = 2'd2,
        SZ_B8  = 2'd3
    } opsize_e;

    typedef enum logic [2:0] {
        OP_PASS    = 3'd0,
        OP_SCAT    = 3'd1,
        OP_GATH    = 3'd2,
        OP_UNSCAT  = 3'd3,
        OP_UNGATH  = 3'd4
    } pass_e;

    typedef struct packed {
        logic    valid;
        logic    inverse;
        opsize_e size;
        logic [2:0] grp;
    } ctrl_t;

    // Permutation applied by pipeline stage idx for a given size and direction.
    function automatic pass_e pass_for(input opsize_e sz, input logic inv, input int idx);
        pass_e r;
        r = OP_PASS;
        if (!inv) begin
            case (sz)
                SZ_W32:  r = (idx == 0) ? OP_SCAT : (idx == 1) ? OP_GATH : OP_PASS;
                SZ_H16:  r = (idx < 2) ? OP_SCAT : OP_GATH;
                SZ_B8:   r = (idx < 3) ? OP_SCAT : OP_PASS;
                default: r = OP_PASS;
            endcase
        end else begin
            case (sz)
                SZ_W32:  r = (idx == 0) ? OP_UNGATH : (idx == 1) ? OP_UNSCAT : OP_PASS;
                SZ_H16:  r = (idx < 2) ? OP_UNGATH : OP_UNSCAT;
                SZ_B8:   r = (idx < 3) ? OP_UNSCAT : OP_PASS;
                default: r = OP_PASS;
            endcase
        end
        return r;
    endfunction

    // Operand groups held by one lane word.
    function automatic logic [2:0] group_mask(input opsize_e sz);
        case (sz)
            SZ_W32:  return 3'd1;
            SZ_H16:  return 3'd3;
            SZ_B8:   return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    // Bit shift per group (log2 of operand width in bits).
    function automatic logic [2:0] width_log2(input opsize_e sz);
        case (sz)
            SZ_W32:  return 3'd5;
            SZ_H16:  return 3'd4;
            SZ_B8:   return 3'd3;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [LANE_BITS-1:0] width_keep(input opsize_e sz);
        case (sz)
            SZ_W32:  return {{(LANE_BITS-32){1'b0}}, {32{1'b1}}};
            SZ_H16:  return {{(LANE_BITS-16){1'b0}}, {16{1'b1}}};
            SZ_B8:   return {{(LANE_BITS-8){1'b0}}, {8{1'b1}}};
            default: return {LANE_BITS{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/bls_pass_stage.sv
module bls_pass_stage
    import bls_pkg::*;
#(
    parameter int LANES     = 64,
    parameter int STAGE_IDX = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ctrl_t                      ctrl_i,
    input  logic [LANES-1:0]           mask_i,
    input  logic [LANES*LANE_BITS-1:0] line_i,
    output ctrl_t                      ctrl_o,
    output logic [LANES-1:0]           mask_o,
    output logic [LANES*LANE_BITS-1:0] line_o
);
    localparam int LINE_BYTES = LANES * LANE_BYTES;
    localparam int HALF_BYTES = LINE_BYTES / 2;
    localparam int HALF_LANE  = LANE_BYTES / 2;

    pass_e op;
    logic [LANES*LANE_BITS-1:0] permuted;

    assign op = pass_for(ctrl_i.size, ctrl_i.inverse, STAGE_IDX);

    for (genvar p = 0; p < LINE_BYTES; p++) begin : g_byte
        localparam int Q          = p % LANE_BYTES;
        localparam int BASE       = p - Q;
        // Perfect shuffle: even outputs from the low half, odd from the high half.
        localparam int SRC_SCAT   = p / 2 + (p % 2) * HALF_BYTES;
        localparam int SRC_UNSCAT = (2 * p) % LINE_BYTES + p / HALF_BYTES;
        // Local gather: even bytes to the low half of the lane, odd bytes above.
        localparam int SRC_GATH   = BASE + (2 * Q) % LANE_BYTES + Q / HALF_LANE;
        localparam int SRC_UNGATH = BASE + Q / 2 + (Q % 2) * HALF_LANE;

        assign permuted[8*p +: 8] =
            (op == OP_SCAT)   ? line_i[8*SRC_SCAT   +: 8] :
            (op == OP_UNSCAT) ? line_i[8*SRC_UNSCAT +: 8] :
            (op == OP_GATH)   ? line_i[8*SRC_GATH   +: 8] :
            (op == OP_UNGATH) ? line_i[8*SRC_UNGATH +: 8] :
                                line_i[8*p          +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            mask_o <= '0;
            line_o <= '0;
        end else begin
            ctrl_o <= ctrl_i;
            mask_o <= mask_i;
            line_o <= permuted;
        end
    end

endmodule

// File: rtl/bls_lane_pick.sv
module bls_lane_pick
    import bls_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ctrl_t                      ctrl_i,
    input  logic [LANES-1:0]           mask_i,
    input  logic [LANES*LANE_BITS-1:0] line_i,
    output logic                       valid_o,
    output logic [LANES-1:0]           lane_valid_o,
    output logic [LANES*LANE_BITS-1:0] line_o
);
    logic [2:0]             grp_eff;
    logic [5:0]             shamt;
    logic [LANE_BITS-1:0]   keep;
    logic [LANES-1:0]       lv_next;
    logic [LANES*LANE_BITS-1:0] data_next;

    assign grp_eff = ctrl_i.grp & group_mask(ctrl_i.size);
    assign shamt   = 6'(grp_eff) << width_log2(ctrl_i.size);
    assign keep    = width_keep(ctrl_i.size);

    for (genvar w = 0; w < LANES; w++) begin : g_lane
        logic [LANE_BITS-1:0] word;
        logic [LANE_BITS-1:0] picked;
        assign word   = line_i[LANE_BITS*w +: LANE_BITS];
        assign picked = (word >> shamt) & keep;
        assign lv_next[w] = ctrl_i.valid & (ctrl_i.inverse | mask_i[w]);
        assign data_next[LANE_BITS*w +: LANE_BITS] =
            !lv_next[w]    ? '0   :
            ctrl_i.inverse ? word : picked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o      <= 1'b0;
            lane_valid_o <= '0;
            line_o       <= '0;
        end else begin
            valid_o      <= ctrl_i.valid;
            lane_valid_o <= lv_next;
            line_o       <= data_next;
        end
    end

endmodule

// File: rtl/byte_lane_shuffle.sv
module byte_lane_shuffle
    import bls_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       inverse,
    input  logic [1:0]                 op_size,
    input  logic [2:0]                 grp_sel,
    input  logic [LANES-1:0]           lane_mask,
    input  logic [LANES*LANE_BITS-1:0] line_in,
    output logic                       out_valid,
    output logic [LANES-1:0]           lane_valid,
    output logic [LANES*LANE_BITS-1:0] line_out
);
    ctrl_t                      ctrl_s [PASS_STAGES+1];
    logic [LANES-1:0]           mask_s [PASS_STAGES+1];
    logic [LANES*LANE_BITS-1:0] line_s [PASS_STAGES+1];

    assign ctrl_s[0] = '{valid: in_valid, inverse: inverse,
                         size: opsize_e'(op_size), grp: grp_sel};
    assign mask_s[0] = lane_mask;
    assign line_s[0] = line_in;

    for (genvar s = 0; s < PASS_STAGES; s++) begin : g_stage
        bls_pass_stage #(.LANES(LANES), .STAGE_IDX(s)) u_pass (
            .clk    (clk),
            .rst    (rst),
            .ctrl_i (ctrl_s[s]),
            .mask_i (mask_s[s]),
            .line_i (line_s[s]),
            .ctrl_o (ctrl_s[s+1]),
            .mask_o (mask_s[s+1]),
            .line_o (line_s[s+1])
        );
    end

    bls_lane_pick #(.LANES(LANES)) u_pick (
        .clk          (clk),
        .rst          (rst),
        .ctrl_i       (ctrl_s[PASS_STAGES]),
        .mask_i       (mask_s[PASS_STAGES]),
        .line_i       (line_s[PASS_STAGES]),
        .valid_o      (out_valid),
        .lane_valid_o (lane_valid),
        .line_o       (line_out)
    );

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
    parameter int LANES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 inverse,
    input logic [1:0]           op_size,
    input logic [LANES-1:0]     lane_mask,
    input logic [LANES*64-1:0]  line_in,
    input logic                 out_valid,
    input logic [LANES-1:0]     lane_valid,
    input logic [LANES*64-1:0]  line_out
);
    localparam int LAT = 5;
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst < 3'(LAT)) since_rst <= since_rst + 3'd1;
    end

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'(LAT)) |-> !out_valid);

    // R10
    idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (lane_valid == '0));

    // R8
    mask_respect_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT) && out_valid && !$past(inverse, LAT))
            |-> ((lane_valid & ~$past(lane_mask, LAT)) == '0));

    // R9
    inverse_all_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT) && out_valid && $past(inverse, LAT))
            |-> (&lane_valid));

    // R3
    dword_identity_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT) && out_valid && !$past(inverse, LAT)
         && $past(op_size, LAT) == 2'd0 && (&$past(lane_mask, LAT)))
            |-> (line_out == $past(line_in, LAT)));

    for (genvar w = 0; w < LANES; w++) begin : g_lane_chk
        // R8
        dead_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !lane_valid[w] |-> (line_out[64*w +: 64] == 64'd0));
    end

endmodule

bind byte_lane_shuffle bls_checker #(.LANES(LANES)) u_bls_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .inverse    (inverse),
    .op_size    (op_size),
    .lane_mask  (lane_mask),
    .line_in    (line_in),
    .out_valid  (out_valid),
    .lane_valid (lane_valid),
    .line_out   (line_out)
);

// File: tb/tb_byte_lane_shuffle.sv
module tb_byte_lane_shuffle;
    localparam int LANES = 64;
    localparam int LBITS = LANES * 64;
    localparam int NVEC  = 14;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic             inverse;
    logic [1:0]       op_size;
    logic [2:0]       grp_sel;
    logic [LANES-1:0] lane_mask;
    logic [LBITS-1:0] line_in;
    logic             out_valid;
    logic [LANES-1:0] lane_valid;
    logic [LBITS-1:0] line_out;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    byte_lane_shuffle #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .inverse(inverse),
        .op_size(op_size), .grp_sel(grp_sel), .lane_mask(lane_mask),
        .line_in(line_in), .out_valid(out_valid), .lane_valid(lane_valid),
        .line_out(line_out)
    );

    // {inverse, op_size, grp_sel, lane_mask}
    localparam logic [69:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF},  // R3
        {1'b0, 2'd0, 3'd5, 64'hAAAA_AAAA_AAAA_AAAA},  // R3 R7 R8
        {1'b0, 2'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF},  // R4
        {1'b0, 2'd1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF},  // R4
        {1'b0, 2'd1, 3'd6, 64'h0F0F_0F0F_0F0F_0F0F},  // R4 R7 R8
        {1'b0, 2'd2, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF},  // R5
        {1'b0, 2'd2, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF},  // R5 R7
        {1'b0, 2'd3, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF},  // R6
        {1'b0, 2'd3, 3'd5, 64'h8000_0000_0000_0001},  // R6 R8
        {1'b0, 2'd3, 3'd7, 64'h0000_0000_0000_0000},  // R6 R8
        {1'b1, 2'd0, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF},  // R9
        {1'b1, 2'd1, 3'd0, 64'h1234_5678_9ABC_DEF0},  // R9
        {1'b1, 2'd2, 3'd6, 64'h0000_0000_0000_0000},  // R9
        {1'b1, 2'd3, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF}   // R9
    };

    function automatic logic [LBITS-1:0] mk_line(input int seed);
        logic [LBITS-1:0] r;
        for (int i = 0; i < LANES*8; i++)
            r[8*i +: 8] = 8'((i*37 + seed*11 + (i/256)*101) & 255);
        return r;
    endfunction

    // Memory-order byte that lands in lane w, byte q, after the forward permutation.
    function automatic int src_byte(input int sz, input int w, input int q);
        case (sz)
            1:       return (q/4)*256 + w*4 + (q%4);
            2:       return (q/2)*128 + w*2 + (q%2);
            3:       return q*64 + w;
            default: return w*8 + q;
        endcase
    endfunction

    function automatic logic [LBITS-1:0] perm_line(input logic [LBITS-1:0] ln, input int sz);
        logic [LBITS-1:0] r;
        for (int w = 0; w < LANES; w++)
            for (int q = 0; q < 8; q++)
                r[8*(w*8+q) +: 8] = ln[8*src_byte(sz, w, q) +: 8];
        return r;
    endfunction

    function automatic logic [LBITS-1:0] exp_fwd(input logic [LBITS-1:0] ln, input int sz,
                                                 input int grp, input logic [LANES-1:0] m);
        logic [LBITS-1:0] r;
        int nb;
        int g;
        r  = '0;
        nb = 8 >> sz;
        g  = grp % (1 << sz);
        for (int w = 0; w < LANES; w++)
            if (m[w])
                for (int j = 0; j < nb; j++)
                    r[8*(w*8+j) +: 8] = ln[8*((g*64+w)*nb + j) +: 8];
        return r;
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_mask(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_line(input string req, input logic [LBITS-1:0] act, input logic [LBITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_vec(input int k);
        logic [69:0] v;
        v         = VEC[k];
        inverse   = v[69];
        op_size   = v[68:67];
        grp_sel   = v[66:64];
        lane_mask = v[63:0];
        line_in   = v[69] ? perm_line(mk_line(k), int'(v[68:67])) : mk_line(k);
        in_valid  = 1'b1;
    endtask

    task automatic check_vec(input int k, input string tag);
        logic [69:0] v;
        v = VEC[k];
        chk_bit({tag, " R2 out_valid"}, out_valid, 1'b1);
        if (v[69]) begin
            chk_mask({tag, " R9 lane_valid"}, lane_valid, '1);
            chk_line({tag, " R9 restored line"}, line_out, mk_line(k));
        end else begin
            chk_mask({tag, " R8 lane_valid"}, lane_valid, v[63:0]);
            chk_line({tag, " R3-R8 lanes"}, line_out,
                     exp_fwd(mk_line(k), int'(v[68:67]), int'(v[66:64]), v[63:0]));
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b1;
        inverse   = 1'b0;
        op_size   = 2'd0;
        grp_sel   = 3'd0;
        lane_mask = '1;
        line_in   = mk_line(99);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk_bit("R1 out_valid in reset", out_valid, 1'b0);
        chk_mask("R1 lane_valid in reset", lane_valid, '0);
        chk_line("R1 line_out in reset", line_out, '0);
        rst      = 1'b0;
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        // R10: idle
        chk_bit("R10 idle out_valid", out_valid, 1'b0);
        chk_mask("R10 idle lane_valid", lane_valid, '0);

        for (int k = 0; k < NVEC; k++) begin
            drive_vec(k);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk_bit($sformatf("vec%0d R2 early", k), out_valid, 1'b0);
            @(negedge clk);
            check_vec(k, $sformatf("vec%0d", k));
            @(negedge clk);
            chk_bit($sformatf("vec%0d R10 after", k), out_valid, 1'b0);
        end

        // R2: back-to-back mixed sizes and modes, in order
        drive_vec(3);
        @(negedge clk);
        drive_vec(12);
        @(negedge clk);
        drive_vec(8);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_vec(3, "b2b0");
        @(negedge clk);
        check_vec(12, "b2b1");
        @(negedge clk);
        check_vec(8, "b2b2");
        @(negedge clk);
        chk_bit("b2b R10 drain", out_valid, 1'b0);

        // R1: reset while a request is in flight
        drive_vec(7);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_bit("R1 flushed request", out_valid, 1'b0);
        chk_line("R1 flushed data", line_out, '0);
        repeat (4) @(negedge clk);
        chk_bit("R1 flushed later", out_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule